// File: doc/BRIEF.md
# Condition Evaluator and Branch Unit

This block takes the four processor flags (zero, negative, overflow, carry) and a four-bit condition code, and reduces them to one boolean. That boolean then drives three things. It decides whether a branch is taken. It is the 0/1 value written by a conditional-set operation. It picks between two register operands for a conditional select. The condition code arrives as two fields: a three-bit selector and a separate invert bit. The invert bit complements the selected function.

Branch targets come in two forms. The absolute form is a 23-bit constant, zero-extended and scaled by four. The relative form is a base register value plus a 16-bit constant, sign-extended and scaled by four. A small program-counter sequencer holds the fetch address. It starts at zero and steps by four on every valid instruction. A taken branch takes effect only after one further sequential instruction, the delay slot, has gone by.

Top module: `cond_branch_unit`

## Requirements
- R1: The code is formed as {sel_i, inv_i}. Codes 0 to 7 evaluate to: 1, 0, C&~Z, ~C|Z, ~C, C, ~Z, Z.
- R2: Codes 8 to 15 evaluate to: ~V, V, ~N, N, N==V, N!=V, ~Z&(N==V), Z|(N!=V).
- R3: For any selector value, setting inv_i to 1 gives the complement of the result obtained with inv_i at 0.
- R4: The absolute target (kind_i = 2) is imm_i zero-extended and multiplied by 4. This places it in the range 0 to 2^25-4, with bits 1:0 always zero.
- R5: The relative target (kind_i = 3) is base_i plus 4 times imm_i[15:0] sign-extended, computed modulo 2^32.
- R6: taken_o is 1 only when valid_i is 1, kind_i is 2 or 3, and the condition holds. For kind_i 0 or 1 it is 0.
- R7: set_o equals the condition result (1 or 0) when kind_i = 1, and is 0 for every other kind.
- R8: sel_o equals opa_i when the condition holds and opb_i otherwise, in the same cycle.
- R9: After reset pc_o is 0. Each cycle with valid_i high moves pc_o to pc_o+4 unless a redirect is due. A cycle with valid_i low leaves pc_o and any pending redirect unchanged.
- R10: After a taken branch at address P, the next valid cycle shows pc_o = P+4 (the delay slot). The valid cycle after that shows the target. next_pc_o always shows the value pc_o will take after the current edge.
- R11: A branch whose condition fails changes nothing in the sequence, which continues at +4.
- R12: A taken branch sitting in the delay slot of an earlier taken branch lets the earlier target execute as its own delay slot. Fetch then goes to the newer target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is present this cycle |
| kind_i | input | 2 | 0 select, 1 conditional set, 2 absolute branch, 3 relative branch |
| sel_i | input | 3 | Condition selector (upper three code bits) |
| inv_i | input | 1 | Condition invert bit (code bit 0) |
| flag_z_i | input | 1 | Zero flag |
| flag_n_i | input | 1 | Negative flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| imm_i | input | 23 | Branch constant |
| base_i | input | 32 | Base register for relative branches |
| opa_i | input | 32 | First select operand |
| opb_i | input | 32 | Second select operand |
| pc_o | output | 32 | Address of the current instruction |
| next_pc_o | output | 32 | Address loaded into pc_o at the next edge |
| taken_o | output | 1 | Branch taken this cycle |
| set_o | output | 1 | Conditional-set result |
| sel_o | output | 32 | Conditional-select result |

## Verification
The condition result, taken_o, set_o, sel_o and next_pc_o are combinational. They are due in the same cycle as the stimulus. pc_o is registered and moves one edge after each valid cycle, so a branch target appears two valid cycles after the branch itself. The driver applies each stimulus on the falling edge and queues the expected values. The monitor compares those values a few nanoseconds later, in that same cycle. The bench's own PC model is advanced only after the expectation for the current cycle has been queued.

// File: rtl/cond_br_pkg.sv
package cond_br_pkg;

  typedef enum logic [1:0] {
    K_SEL = 2'd0,
    K_SET = 2'd1,
    K_ABS = 2'd2,
    K_REL = 2'd3
  } br_kind_e;

  // Base (non-inverted) function for each selector value.
  function automatic logic base_cond(input logic [2:0] sel,
                                     input logic z, input logic n,
                                     input logic v, input logic c);
    logic ge;
    ge = ~(n ^ v);
    case (sel)
      3'd0:    base_cond = 1'b1;
      3'd1:    base_cond = c & ~z;
      3'd2:    base_cond = ~c;
      3'd3:    base_cond = ~z;
      3'd4:    base_cond = ~v;
      3'd5:    base_cond = ~n;
      3'd6:    base_cond = ge;
      default: base_cond = ~z & ge;
    endcase
  endfunction

  function automatic logic [31:0] abs_target(input logic [22:0] imm);
    abs_target = {7'd0, imm, 2'b00};
  endfunction

  function automatic logic [31:0] rel_target(input logic [31:0] base,
                                             input logic [15:0] imm);
    rel_target = base + {{14{imm[15]}}, imm, 2'b00};
  endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval (
  input  logic [2:0] sel_i,
  input  logic       inv_i,
  input  logic       z_i,
  input  logic       n_i,
  input  logic       v_i,
  input  logic       c_i,
  output logic       hold_o
);
  import cond_br_pkg::*;

  logic raw;

  always_comb begin
    raw    = base_cond(sel_i, z_i, n_i, v_i, c_i);
    hold_o = raw ^ inv_i;
  end

endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int XLEN  = 32,
  parameter int ABS_W = 23
) (
  input  logic             rel_i,
  input  logic [ABS_W-1:0] imm_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  tgt_o
);
  import cond_br_pkg::*;

  logic [XLEN-1:0] abs_t;
  logic [XLEN-1:0] rel_t;

  always_comb begin
    abs_t = abs_target(imm_i);
    rel_t = rel_target(base_i, imm_i[15:0]);
    tgt_o = rel_i ? rel_t : abs_t;
  end

endmodule

// File: rtl/pc_seq.sv
module pc_seq #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] tgt_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] next_pc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] pc_q;
  logic            pend_q;
  logic [XLEN-1:0] pend_tgt_q;
  logic            redirect_w;

  assign redirect_w = valid_i & pend_q;

  always_comb begin
    if (!valid_i)       next_pc_o = pc_q;
    else if (redirect_w) next_pc_o = pend_tgt_q;
    else                next_pc_o = pc_q + STEP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q       <= '0;
      pend_q     <= 1'b0;
      pend_tgt_q <= '0;
    end else if (valid_i) begin
      pc_q   <= next_pc_o;
      pend_q <= take_i;
      if (take_i) pend_tgt_q <= tgt_i;
    end
  end

  assign pc_o = pc_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(pc_o)); // R9
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !pend_q) |=> (pc_o == $past(pc_o) + STEP)); // R9
  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_w |=> (pc_o == $past(pend_tgt_q))); // R10
  AST_TAKE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && take_i) |=> pend_q); // R12

endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int XLEN  = 32,
  parameter int ABS_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [1:0]       kind_i,
  input  logic [2:0]       sel_i,
  input  logic             inv_i,
  input  logic             flag_z_i,
  input  logic             flag_n_i,
  input  logic             flag_v_i,
  input  logic             flag_c_i,
  input  logic [ABS_W-1:0] imm_i,
  input  logic [XLEN-1:0]  base_i,
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             taken_o,
  output logic             set_o,
  output logic [XLEN-1:0]  sel_o
);
  import cond_br_pkg::*;

  logic            cond_w;
  logic            is_branch_w;
  logic [XLEN-1:0] tgt_w;

  cond_eval u_eval (
    .sel_i (sel_i),
    .inv_i (inv_i),
    .z_i   (flag_z_i),
    .n_i   (flag_n_i),
    .v_i   (flag_v_i),
    .c_i   (flag_c_i),
    .hold_o(cond_w)
  );

  br_target #(.XLEN(XLEN), .ABS_W(ABS_W)) u_tgt (
    .rel_i (kind_i == K_REL),
    .imm_i (imm_i),
    .base_i(base_i),
    .tgt_o (tgt_w)
  );

  assign is_branch_w = (kind_i == K_ABS) || (kind_i == K_REL);
  assign taken_o     = valid_i & is_branch_w & cond_w;
  assign set_o       = (kind_i == K_SET) & cond_w;
  assign sel_o       = cond_w ? opa_i : opb_i;

  pc_seq #(.XLEN(XLEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .take_i   (taken_o),
    .tgt_i    (tgt_w),
    .pc_o     (pc_o),
    .next_pc_o(next_pc_o)
  );

  AST_NO_TAKE_NONBRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_SET || kind_i == K_SEL) |-> !taken_o); // R6
  AST_SET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |-> (sel_o == opa_i)); // R7

endmodule

// File: tb/sim_cond_branch_unit.sv
module sim_cond_branch_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [2:0]  sel_i = '0;
  logic        inv_i = 1'b0;
  logic        fz = 1'b0, fn = 1'b0, fv = 1'b0, fc = 1'b0;
  logic [22:0] imm_i = '0;
  logic [31:0] base_i = '0, opa_i = '0, opb_i = '0;
  logic [31:0] pc_o, next_pc_o, sel_o;
  logic        taken_o, set_o;

  always #5 clk = ~clk;

  cond_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
    .sel_i(sel_i), .inv_i(inv_i), .flag_z_i(fz), .flag_n_i(fn),
    .flag_v_i(fv), .flag_c_i(fc), .imm_i(imm_i), .base_i(base_i),
    .opa_i(opa_i), .opb_i(opb_i), .pc_o(pc_o), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .set_o(set_o), .sel_o(sel_o)
  );

  typedef struct {
    string       tag;
    logic [31:0] pc;
    logic [31:0] npc;
    logic        taken;
    logic        setv;
    logic [31:0] selv;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;

  logic [31:0] m_pc = 0;
  logic        m_pend = 0;
  logic [31:0] m_tgt = 0;

  // Truth written per full code, flags as given.
  function automatic logic ref_cond(input logic [3:0] code,
                                    input logic z, input logic n,
                                    input logic v, input logic c);
    case (code)
      4'h0: return 1;           4'h1: return 0;
      4'h2: return c && !z;     4'h3: return !c || z;
      4'h4: return !c;          4'h5: return c;
      4'h6: return !z;          4'h7: return z;
      4'h8: return !v;          4'h9: return v;
      4'hA: return !n;          4'hB: return n;
      4'hC: return n == v;      4'hD: return n != v;
      4'hE: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic step(input logic vld, input logic [1:0] kind,
                      input logic [3:0] code, input logic [3:0] zn_vc,
                      input logic [22:0] imm, input logic [31:0] base,
                      input string tag);
    exp_t e;
    logic cnd;
    logic [31:0] tgt;
    @(negedge clk);
    valid_i = vld; kind_i = kind; sel_i = code[3:1]; inv_i = code[0];
    {fz, fn, fv, fc} = zn_vc; imm_i = imm; base_i = base;
    opa_i = 32'hA5A5_0000 ^ {28'd0, code}; opb_i = 32'h0F0F_1234;
    cnd = ref_cond(code, zn_vc[3], zn_vc[2], zn_vc[1], zn_vc[0]);
    if (kind == 2'd2) tgt = 32'(imm) * 4;
    else tgt = base + 32'($signed(imm[15:0])) * 4;
    e.tag   = tag;
    e.pc    = m_pc;
    e.taken = vld && kind[1] && cnd;
    e.setv  = (kind == 2'd1) && cnd;
    e.selv  = cnd ? opa_i : opb_i;
    e.npc   = !vld ? m_pc : (m_pend ? m_tgt : m_pc + 4);
    q.push_back(e);
    if (vld) begin
      m_pc   = e.npc;
      m_pend = e.taken;
      if (e.taken) m_tgt = tgt;
    end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        e = q.pop_front();
        compared++;
        cmp(e.tag, "pc_o", pc_o, e.pc);
        cmp(e.tag, "next_pc_o", next_pc_o, e.npc);
        cmp(e.tag, "taken_o", {31'd0, taken_o}, {31'd0, e.taken});
        cmp(e.tag, "set_o", {31'd0, set_o}, {31'd0, e.setv});
        cmp(e.tag, "sel_o", sel_o, e.selv);
      end
    end
  end

  initial begin : watchdog
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset value and idle hold
    step(0, 2'd0, 4'h0, 4'h0, 0, 0, "R9");
    step(0, 2'd0, 4'h0, 4'h0, 0, 0, "R9");
    // R1 R2 R3 R7 R8: every code against every flag pattern, set and select
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        step(1, 2'd1, 4'(c), 4'(f), 0, 0, (c < 8) ? "R1" : "R2");
        step(1, 2'd0, 4'(c), 4'(f), 0, 0, "R8");
      end
    end
    // R6: set/select kinds never take, even when true
    step(1, 2'd1, 4'h0, 4'h0, 23'h100, 0, "R6");
    // R6: branch with valid low does not take, R9 hold
    step(0, 2'd2, 4'h0, 4'h0, 23'h100, 0, "R6");
    step(0, 2'd2, 4'h0, 4'h0, 23'h100, 0, "R9");
    // R4 R10: absolute taken, shadow, then target
    step(1, 2'd2, 4'h0, 4'h0, 23'h7F_FFFF, 0, "R4");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R10");
    step(0, 2'd0, 4'h1, 4'h0, 0, 0, "R10");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R10");
    // R11: failing condition (EQ with Z clear) is a no-op
    step(1, 2'd2, 4'h7, 4'h0, 23'h40, 0, "R11");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R11");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R11");
    // R5: relative with negative offset, then positive with wrap
    step(1, 2'd3, 4'h6, 4'h0, 23'h7F_FFFC, 32'h0000_1000, "R5");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R5");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R5");
    step(1, 2'd3, 4'h0, 4'h0, 23'h00_0010, 32'hFFFF_FFF0, "R5");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R5");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R5");
    // R12: taken branch in the delay slot of a taken branch
    step(1, 2'd2, 4'h0, 4'h0, 23'h200, 0, "R12");
    step(1, 2'd2, 4'h0, 4'h0, 23'h300, 0, "R12");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R12");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R12");
    step(1, 2'd0, 4'h1, 4'h0, 0, 0, "R12");
    step(0, 2'd0, 4'h1, 4'h0, 0, 0, "R12");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule